// File: doc/BRIEF.md
# Equalizer Sleep and Mute Controller

This block decides whether a cable-equalizer receive path is powered and whether its differential output is forced to zero. A 2-bit policy field selects one of three behaviours. The path can stay powered permanently. It can follow the presence of an input signal, powering down after a bounded quiet time and waking as soon as the signal returns. Or it can be held off whatever the input does. A separate mute control forces the output low, but only while the path is powered. Sleep therefore always wins over mute.

The raw signal-present indication comes from an analog detector in another clock domain. It is resynchronized here and published two ways: as a status bit for register readback (1 = carrier present) and as an active-low pin (low = carrier present). The power-down delay is measured in ticks of a free-running microsecond strobe. The tick count is a parameter, capped at 200 so that power-down completes within 200 µs of signal loss.

Top module: `eq_sleep_ctrl`

## Requirements
- R1: With `sleep_mode_i` at 2'b00 (never sleep) or the reserved 2'b11, `pwr_en_o` is 1 one clock after the mode is sampled, whatever the signal state.
- R2: With `sleep_mode_i` at 2'b10 (forced sleep), `pwr_en_o` is 0 one clock after the mode is sampled, even with a signal present.
- R3: With `sleep_mode_i` at 2'b01 (auto sleep), `pwr_en_o` is 1 while the synchronized signal is present. It drops one clock after `LOS_TICKS` ticks have been sampled with the synchronized signal absent. `LOS_TICKS` must lie in 1..200 (default 150).
- R4: In auto sleep, the quiet-time count restarts whenever the synchronized signal returns. `pwr_en_o` rises one clock after the synchronized signal is seen, with no tick needed.
- R5: While the path is powered, `out_mute_o` equals `mute_i` as sampled one clock earlier. A 1 forces the output low and a 0 leaves it active.
- R6: Sleep takes precedence over mute. Whenever `pwr_en_o` is 0, `out_mute_o` is 0, and `mute_i` never changes `pwr_en_o`.
- R7: `cd_stat_o` equals `sig_raw_i` delayed by two clocks (1 = carrier present), and `cd_n_o` is its complement (low = carrier present).
- R8: During and right after reset, `pwr_en_o`=0, `out_mute_o`=0, `cd_stat_o`=0 and `cd_n_o`=1. The quiet-time count starts as already expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe, one per microsecond |
| sleep_mode_i | input | 2 | Sleep policy: 00 never, 01 auto, 10 forced, 11 treated as never |
| mute_i | input | 1 | Output mute request |
| sig_raw_i | input | 1 | Unsynchronized signal-present indication |
| pwr_en_o | output | 1 | Receive path power enable |
| out_mute_o | output | 1 | Force equalizer output to zero |
| cd_stat_o | output | 1 | Carrier status for readback, 1 = present |
| cd_n_o | output | 1 | Carrier-detect pin, low = present |

## Verification
The assertions assume that `tick_i` is a single-cycle strobe and that `sleep_mode_i` and `mute_i` are synchronous to `clk_i`. Only `sig_raw_i` may arrive asynchronously. The stimulus drives every input on the falling edge, and it holds `sig_raw_i` for long random stretches so that both quiet times shorter than the limit and quiet times past it occur. The quiet-time assertion counts ticks only while auto mode holds and the carrier is absent. The stimulus changes the mode rarely, so that many uninterrupted windows reach the limit.

// File: rtl/eq_sleep_pkg.sv
package eq_sleep_pkg;
  typedef enum logic [1:0] {
    SLP_NEVER = 2'b00,
    SLP_AUTO  = 2'b01,
    SLP_FORCE = 2'b10,
    SLP_RSVD  = 2'b11
  } slp_mode_e;
endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/los_timer.sv
module los_timer #(
  parameter int unsigned LOS_TICKS = 150
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sig_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (LOS_TICKS < 2) ? 1 : $clog2(LOS_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOS_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;

  // Starts expired: no signal has been seen since reset.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b1;
    end else if (sig_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (tick_i && !exp_q) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        exp_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign expired_o = exp_q;
endmodule

// File: rtl/pwr_mute_ctrl.sv
module pwr_mute_ctrl
  import eq_sleep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sleep_mode_i,
  input  logic       mute_i,
  input  logic       sig_i,
  input  logic       expired_i,
  output logic       pwr_en_o,
  output logic       out_mute_o
);
  slp_mode_e mode;
  logic      pwr_d;

  assign mode = slp_mode_e'(sleep_mode_i);

  always_comb begin
    unique case (mode)
      SLP_AUTO:  pwr_d = sig_i | ~expired_i;
      SLP_FORCE: pwr_d = 1'b0;
      default:   pwr_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_en_o   <= 1'b0;
      out_mute_o <= 1'b0;
    end else begin
      pwr_en_o   <= pwr_d;
      out_mute_o <= mute_i & pwr_d;  // sleep wins over mute
    end
  end
endmodule

// File: rtl/eq_sleep_ctrl.sv
module eq_sleep_ctrl #(
  parameter int unsigned LOS_TICKS   = 150,  // 1..200 microsecond ticks
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] sleep_mode_i,
  input  logic       mute_i,
  input  logic       sig_raw_i,
  output logic       pwr_en_o,
  output logic       out_mute_o,
  output logic       cd_stat_o,
  output logic       cd_n_o
);
  logic sig_s;
  logic los_exp;

  sig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sig_raw_i),
    .q_o   (sig_s)
  );

  los_timer #(.LOS_TICKS(LOS_TICKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .sig_i    (sig_s),
    .expired_o(los_exp)
  );

  pwr_mute_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_mode_i(sleep_mode_i),
    .mute_i      (mute_i),
    .sig_i       (sig_s),
    .expired_i   (los_exp),
    .pwr_en_o    (pwr_en_o),
    .out_mute_o  (out_mute_o)
  );

  assign cd_stat_o = sig_s;
  assign cd_n_o    = ~sig_s;
endmodule

// File: rtl/eq_sleep_ctrl_chk.sv
module eq_sleep_ctrl_chk #(
  parameter int unsigned LOS_TICKS = 150
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [1:0] sleep_mode_i,
  input logic       mute_i,
  input logic       sig_raw_i,
  input logic       pwr_en_o,
  input logic       out_mute_o,
  input logic       cd_stat_o,
  input logic       cd_n_o
);
  logic [1:0] warm_q;
  int unsigned quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // Ticks seen while auto mode holds and the carrier is absent.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) quiet_q <= 0;
    else if (sleep_mode_i != 2'b01 || cd_stat_o) quiet_q <= 0;
    else if (tick_i && quiet_q < LOS_TICKS) quiet_q <= quiet_q + 1;
  end

  p_never_on_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_mode_i == 2'b00 || sleep_mode_i == 2'b11) |=> pwr_en_o);

  p_force_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_mode_i == 2'b10) |=> !pwr_en_o);

  p_los_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q == LOS_TICKS && sleep_mode_i == 2'b01 && !cd_stat_o) |=> !pwr_en_o);

  p_wake_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_mode_i == 2'b01 && cd_stat_o) |=> pwr_en_o);

  p_sleep_over_mute_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> !out_mute_o);

  p_cd_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (cd_stat_o == $past(sig_raw_i, 2) && cd_n_o != cd_stat_o));
endmodule

bind eq_sleep_ctrl eq_sleep_ctrl_chk #(.LOS_TICKS(LOS_TICKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .sleep_mode_i(sleep_mode_i),
  .mute_i      (mute_i),
  .sig_raw_i   (sig_raw_i),
  .pwr_en_o    (pwr_en_o),
  .out_mute_o  (out_mute_o),
  .cd_stat_o   (cd_stat_o),
  .cd_n_o      (cd_n_o)
);

// File: tb/eq_sleep_ctrl_tb.sv
module eq_sleep_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOS = 12;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       mute = 1'b0;
  logic       raw = 1'b0;
  logic       pwr, omute, cds, cdn;

  int n_chk = 0;
  int n_fail = 0;
  string pwr_tag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  eq_sleep_ctrl #(.LOS_TICKS(LOS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .sleep_mode_i(mode),
    .mute_i(mute), .sig_raw_i(raw), .pwr_en_o(pwr), .out_mute_o(omute),
    .cd_stat_o(cds), .cd_n_o(cdn)
  );

  // Reference built from the requirements.
  logic m_s1, m_s2, m_exp, m_pwr, m_mute;
  int   m_quiet;

  function automatic logic exp_pwr(logic [1:0] md, logic sig, logic expd);
    case (md)
      2'b10:   return 1'b0;            // R2
      2'b01:   return sig | ~expd;     // R3, R4
      default: return 1'b1;            // R1
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 <= 0; m_s2 <= 0; m_exp <= 1; m_quiet <= 0; m_pwr <= 0; m_mute <= 0;
    end else begin
      m_s1 <= raw;
      m_s2 <= m_s1;
      if (m_s2) begin m_quiet <= 0; m_exp <= 0; end
      else if (tick && !m_exp) begin
        if (m_quiet + 1 == LOS) begin m_quiet <= 0; m_exp <= 1; end
        else m_quiet <= m_quiet + 1;
      end
      m_pwr  <= exp_pwr(mode, m_s2, m_exp);
      m_mute <= mute & exp_pwr(mode, m_s2, m_exp);
    end
  end

  task automatic check(string req, logic act, logic expv, string what);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic compare();
    string t;
    if (pwr_tag != "") t = pwr_tag;
    else if (mode == 2'b10) t = "R2";
    else if (mode == 2'b01) t = "R3";
    else t = "R1";
    check(t, pwr, m_pwr, "pwr_en");
    check(m_pwr ? "R5" : "R6", omute, m_mute, "out_mute");
    check("R7", cds, m_s2, "cd_stat");
    check("R7", cdn, ~m_s2, "cd_n");
  endtask

  task automatic step(logic [1:0] md, logic mt, logic rw, logic tk);
    @(negedge clk);
    compare();
    mode = md; mute = mt; raw = rw; tick = tk;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    raw = 1'b1; mute = 1'b1;
    repeat (3) @(negedge clk);
    // R8: reset state while reset is held, signal and mute requested
    check("R8", pwr, 1'b0, "pwr_en in reset");
    check("R8", omute, 1'b0, "out_mute in reset");
    check("R8", cds, 1'b0, "cd_stat in reset");
    check("R8", cdn, 1'b1, "cd_n in reset");
    raw = 1'b0; mute = 1'b0;
    rst_ni = 1'b1;
    // R8: timer expired at start, auto mode with no signal stays off
    for (int i = 0; i < 4; i++) step(2'b01, 1'b0, 1'b0, 1'b0);
    check("R8", pwr, 1'b0, "auto after reset, no signal");

    // R1: never-sleep and reserved code power on without signal
    for (int i = 0; i < 4; i++) step(2'b00, 1'b0, 1'b0, 1'b1);
    check("R1", pwr, 1'b1, "mode 00 no signal");
    for (int i = 0; i < 4; i++) step(2'b11, 1'b0, 1'b0, 1'b1);
    check("R1", pwr, 1'b1, "mode 11 no signal");

    // R2: forced sleep with signal present; R6: mute has no effect
    for (int i = 0; i < 6; i++) step(2'b10, 1'b1, 1'b1, 1'b1);
    check("R2", pwr, 1'b0, "forced with signal");
    check("R6", omute, 1'b0, "mute while forced asleep");

    // R5: mute while powered
    for (int i = 0; i < 4; i++) step(2'b00, 1'b1, 1'b1, 1'b0);
    check("R5", omute, 1'b1, "mute while powered");

    // R4: short gaps restart the timer, power stays on
    pwr_tag = "R4";
    for (int g = 0; g < 4; g++) begin
      for (int i = 0; i < 6; i++) step(2'b01, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < LOS - 3; i++) step(2'b01, 1'b0, 1'b0, 1'b1);
    end
    for (int i = 0; i < 4; i++) step(2'b01, 1'b0, 1'b1, 1'b1);
    check("R4", pwr, 1'b1, "after repeated short gaps");
    pwr_tag = "";

    // R3: full loss with one tick per cycle, drop at exact cycle
    for (int i = 0; i < LOS + 6; i++) step(2'b01, 1'b0, 1'b0, 1'b1);
    check("R3", pwr, 1'b0, "after full quiet time");

    // Random phase
    begin
      logic [1:0] md = 2'b01;
      logic mt = 1'b0, rw = 1'b0;
      for (int c = 0; c < 20000; c++) begin
        if ($urandom_range(199) == 0) md = 2'($urandom_range(3));
        if ($urandom_range(29) == 0)  mt = ~mt;
        if ($urandom_range(39) == 0)  rw = ~rw;
        step(md, mt, rw, ($urandom_range(2) == 0));
      end
    end
    @(negedge clk);
    compare();
    summary();
    $finish;
  end
endmodule